// File: doc/BRIEF.md
# Split-Transaction Outstanding Request Table

This block tracks bus transactions that are in flight for one cache controller on a snooping bus. On that bus, requests and responses travel on separate lines. Each table slot stands for one outstanding transaction. The slot number is the tag that the request carries on the bus. The response that comes back much later carries the same tag. Every core holds an identical copy of the table. Each copy allocates slots from requests it issues itself and from requests it snoops from other cores, and it frees slots from every response it observes.

The local request port is a combinational lookup by block address. A new request is accepted in one of two ways. It may be given the lowest free slot, and then it appears on the issue outputs with that slot as its tag. Or, when it is a read that hits an outstanding read to the same block, it merges into that slot without any new bus traffic. A request that conflicts with an outstanding transaction to its block is held back with ready low. So is a request that arrives while the table is full. Each slot keeps a bitmask of the local requesters waiting on it. When the response arrives, a result pulse reports the tag and that mask, so that every waiter can be woken. A response or a snooped request whose tag contradicts the table raises an error pulse and changes nothing.

Top module: `split_txn_table`

## Requirements
- R1: After reset every slot is free. `lcl_ready` is high, `iss_valid`, `done_valid` and `tag_err` are low, and the first accepted request gets tag 0.
- R2: A local request that is neither merged nor stalled is accepted in the same cycle. `iss_valid` is high, `iss_tag`/`lcl_tag` give the lowest-numbered free slot, and `iss_block`/`iss_read` repeat the request.
- R3: A response (`rsp_valid`) whose tag names a busy slot frees that slot. In the next cycle `done_valid` is 1 for one cycle, with `done_tag` equal to the tag and `done_mask` equal to the slot's waiter mask. Bit k of the mask stands for local requester k (`lcl_who` = k).
- R4: A freed slot may be handed out again. Allocation takes whichever slot is the lowest free one, regardless of the order in which slots were taken.
- R5: A snooped request (`snp_valid`) to a free slot occupies the slot named by `snp_tag`, with an empty waiter mask. Local allocation then skips that slot, and a local write to that block stalls.
- R6: At most one outstanding transaction exists per block. A local request that hits a busy slot for the same block stalls with `lcl_ready` low and `iss_valid` low, unless R7 applies.
- R7: A local read (`lcl_read`=1) that hits an outstanding read to the same block merges. `lcl_ready` and `lcl_merge` are high, `iss_valid` is low, `lcl_tag` is the existing slot, and the requester's bit joins that slot's waiter mask.
- R8: When all slots are busy, a request that cannot merge stalls. A read that can merge is still accepted by merging.
- R9: A response whose tag names a free slot produces `tag_err`=1 for one cycle, in the next cycle, with no `done_valid`. The table is left unchanged.
- R10: A snooped request whose tag names a busy slot produces `tag_err` in the next cycle and leaves that slot and its block unchanged.
- R11: In a cycle with `snp_valid` high, the local port stalls (`lcl_ready` low). The snooped request is recorded.
- R12: A slot that is being freed in the current cycle takes no part in the lookup and is not counted as free. A local request to its block is treated as having no outstanding match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcl_valid | input | 1 | Local request present |
| lcl_block | input | AW | Block address of the local request |
| lcl_read | input | 1 | 1 = read miss, 0 = write or upgrade |
| lcl_who | input | $clog2(NW) | Local requester number |
| lcl_ready | output | 1 | Local request can be accepted this cycle |
| lcl_merge | output | 1 | Accepted request merged into an outstanding read |
| lcl_tag | output | TW | Slot used by the accepted request |
| iss_valid | output | 1 | New request to broadcast on the request lines |
| iss_tag | output | TW | Tag carried by the broadcast request |
| iss_block | output | AW | Block address of the broadcast request |
| iss_read | output | 1 | Kind of the broadcast request |
| snp_valid | input | 1 | Request from another core seen on the request lines |
| snp_tag | input | TW | Tag of the snooped request |
| snp_block | input | AW | Block of the snooped request |
| snp_read | input | 1 | Kind of the snooped request |
| rsp_valid | input | 1 | Response seen on the response lines |
| rsp_tag | input | TW | Tag of the response |
| done_valid | output | 1 | A slot retired in the previous cycle |
| done_tag | output | TW | Retired slot |
| done_mask | output | NW | Local waiters to wake |
| tag_err | output | 1 | Response or snoop tag contradicted the table |

## Verification
The bench builds the block with its defaults: 8 slots, 4 local requesters and 16-bit block addresses. With 8 slots the table can be filled in a handful of requests. That exposes stalls on a full table while a merge stays possible, and slot reuse out of order. With 4 requesters, a mask made of several merged waiters can be told apart from the allocating requester's own bit. The bench drives same-cycle pairs: a snoop together with a local request, and a response together with a local request to the retiring block. These cover the priority and lookup masking rules.

// File: rtl/stt_pkg.sv
package stt_pkg;

  // Index of the lowest set bit of a vector of up to 64 bits (0 when none).
  function automatic logic [5:0] first_set(input logic [63:0] v);
    logic [5:0] r;
    r = '0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) r = 6'(i);
    end
    return r;
  endfunction

  // Single bit at position idx of a 64-bit mask.
  function automatic logic [63:0] bit_at(input logic [5:0] idx);
    return 64'(1) << idx;
  endfunction

endpackage

// File: rtl/stt_pick.sv
module stt_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  import stt_pkg::*;

  logic [5:0] raw;

  always_comb begin
    raw   = first_set(64'(vec_i));
    any_o = |vec_i;
    idx_o = IW'(raw);
  end

endmodule

// File: rtl/stt_slot.sv
module stt_slot #(
  parameter int AW = 16,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic [AW-1:0] take_blk_i,
  input  logic          take_rd_i,
  input  logic [NW-1:0] take_mask_i,
  input  logic          join_i,
  input  logic [NW-1:0] join_mask_i,
  input  logic          drop_i,
  input  logic [AW-1:0] probe_blk_i,
  output logic          busy_o,
  output logic          rd_o,
  output logic          match_o,
  output logic [NW-1:0] mask_o
);

  logic [AW-1:0] blk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      blk_q  <= '0;
      rd_o   <= 1'b0;
      mask_o <= '0;
    end else if (take_i) begin
      busy_o <= 1'b1;
      blk_q  <= take_blk_i;
      rd_o   <= take_rd_i;
      mask_o <= take_mask_i;
    end else if (drop_i) begin
      busy_o <= 1'b0;
      mask_o <= '0;
    end else if (join_i) begin
      mask_o <= mask_o | join_mask_i;
    end
  end

  assign match_o = busy_o && (blk_q == probe_blk_i);

endmodule

// File: rtl/split_txn_table.sv
module split_txn_table #(
  parameter int NENT = 8,
  parameter int NW   = 4,
  parameter int AW   = 16,
  localparam int TW  = (NENT > 1) ? $clog2(NENT) : 1,
  localparam int WHW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           lcl_valid,
  input  logic [AW-1:0]  lcl_block,
  input  logic           lcl_read,
  input  logic [WHW-1:0] lcl_who,
  output logic           lcl_ready,
  output logic           lcl_merge,
  output logic [TW-1:0]  lcl_tag,
  output logic           iss_valid,
  output logic [TW-1:0]  iss_tag,
  output logic [AW-1:0]  iss_block,
  output logic           iss_read,
  input  logic           snp_valid,
  input  logic [TW-1:0]  snp_tag,
  input  logic [AW-1:0]  snp_block,
  input  logic           snp_read,
  input  logic           rsp_valid,
  input  logic [TW-1:0]  rsp_tag,
  output logic           done_valid,
  output logic [TW-1:0]  done_tag,
  output logic [NW-1:0]  done_mask,
  output logic           tag_err
);

  // Named internal events (observed by the bound checker)
  logic [NENT-1:0] busy_vec;
  logic [NENT-1:0] rd_vec;
  logic [NENT-1:0] match_vec;
  logic [NENT-1:0] drop_vec;
  logic [NENT-1:0] take_vec;
  logic [NENT-1:0] join_vec;
  logic [NW-1:0]   mask_arr [NENT];

  logic [NENT-1:0] live_hit;
  logic            hit_any;
  logic [TW-1:0]   hit_idx;
  logic            free_any;
  logic [TW-1:0]   free_idx;
  logic            can_merge;
  logic            accept;
  logic            snp_ok;
  logic            snp_bad;
  logic            rsp_bad;
  logic [NW-1:0]   who_mask;

  // Lookup: slots retiring this cycle are invisible (R12)
  assign live_hit = match_vec & ~drop_vec;

  stt_pick #(.N(NENT)) u_hit_pick (
    .vec_i (live_hit),
    .any_o (hit_any),
    .idx_o (hit_idx)
  );

  stt_pick #(.N(NENT)) u_free_pick (
    .vec_i (~busy_vec),
    .any_o (free_any),
    .idx_o (free_idx)
  );

  assign who_mask  = NW'(1) << lcl_who;
  assign can_merge = hit_any && lcl_read && rd_vec[hit_idx];
  assign lcl_ready = !snp_valid && (can_merge || (!hit_any && free_any));
  assign accept    = lcl_valid && lcl_ready;
  assign lcl_merge = accept && can_merge;
  assign lcl_tag   = can_merge ? hit_idx : free_idx;
  assign iss_valid = accept && !can_merge;
  assign iss_tag   = free_idx;
  assign iss_block = lcl_block;
  assign iss_read  = lcl_read;

  assign snp_ok  = snp_valid && !busy_vec[snp_tag];
  assign snp_bad = snp_valid &&  busy_vec[snp_tag];
  assign rsp_bad = rsp_valid && !busy_vec[rsp_tag];

  genvar g;
  generate
    for (g = 0; g < NENT; g++) begin : g_slot
      logic          own_take;
      logic          far_take;
      logic [AW-1:0] t_blk;
      logic          t_rd;
      logic [NW-1:0] t_mask;

      assign own_take    = iss_valid && (free_idx == TW'(g));
      assign far_take    = snp_ok && (snp_tag == TW'(g));
      assign take_vec[g] = own_take || far_take;
      assign drop_vec[g] = rsp_valid && (rsp_tag == TW'(g)) && busy_vec[g];
      assign join_vec[g] = lcl_merge && (hit_idx == TW'(g));
      assign t_blk       = far_take ? snp_block : lcl_block;
      assign t_rd        = far_take ? snp_read  : lcl_read;
      assign t_mask      = far_take ? '0        : who_mask;

      stt_slot #(.AW(AW), .NW(NW)) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (take_vec[g]),
        .take_blk_i  (t_blk),
        .take_rd_i   (t_rd),
        .take_mask_i (t_mask),
        .join_i      (join_vec[g]),
        .join_mask_i (who_mask),
        .drop_i      (drop_vec[g]),
        .probe_blk_i (lcl_block),
        .busy_o      (busy_vec[g]),
        .rd_o        (rd_vec[g]),
        .match_o     (match_vec[g]),
        .mask_o      (mask_arr[g])
      );
    end
  endgenerate

  // Result register: one-cycle pulses after the observed response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_valid <= 1'b0;
      done_tag   <= '0;
      done_mask  <= '0;
      tag_err    <= 1'b0;
    end else begin
      done_valid <= rsp_valid && !rsp_bad;
      tag_err    <= rsp_bad || snp_bad;
      if (rsp_valid && !rsp_bad) begin
        done_tag  <= rsp_tag;
        done_mask <= mask_arr[rsp_tag];
      end
    end
  end

endmodule

// File: rtl/stt_checker.sv
module stt_checker #(
  parameter int NENT = 8,
  localparam int TW  = (NENT > 1) ? $clog2(NENT) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lcl_valid,
  input logic            lcl_ready,
  input logic            lcl_merge,
  input logic            iss_valid,
  input logic [TW-1:0]   iss_tag,
  input logic            snp_valid,
  input logic            rsp_valid,
  input logic [TW-1:0]   rsp_tag,
  input logic            done_valid,
  input logic [TW-1:0]   done_tag,
  input logic            tag_err,
  input logic [NENT-1:0] busy_vec,
  input logic [NENT-1:0] match_vec,
  input logic [NENT-1:0] take_vec,
  input logic [NENT-1:0] drop_vec
);

  AST_ISSUE_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !busy_vec[iss_tag]); // R2

  AST_DONE_FOLLOWS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && busy_vec[rsp_tag]) |=> (done_valid && done_tag == $past(rsp_tag))); // R3

  AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && busy_vec[rsp_tag]) |=> !busy_vec[$past(rsp_tag)]); // R3

  AST_ONE_PER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(match_vec) <= 1); // R6

  AST_MERGE_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_valid && lcl_merge)); // R7

  AST_FULL_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    ((&busy_vec) && lcl_valid) |-> !iss_valid); // R8

  AST_BAD_RSP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !busy_vec[rsp_tag]) |=> (tag_err && !done_valid)); // R9

  AST_SNOOP_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !lcl_ready); // R11

  AST_TAKE_DROP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (take_vec & drop_vec) == '0); // R12

endmodule

bind split_txn_table stt_checker #(.NENT(NENT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lcl_valid  (lcl_valid),
  .lcl_ready  (lcl_ready),
  .lcl_merge  (lcl_merge),
  .iss_valid  (iss_valid),
  .iss_tag    (iss_tag),
  .snp_valid  (snp_valid),
  .rsp_valid  (rsp_valid),
  .rsp_tag    (rsp_tag),
  .done_valid (done_valid),
  .done_tag   (done_tag),
  .tag_err    (tag_err),
  .busy_vec   (busy_vec),
  .match_vec  (match_vec),
  .take_vec   (take_vec),
  .drop_vec   (drop_vec)
);

// File: tb/split_txn_table_test.sv
module split_txn_table_test;

  localparam int NENT = 8;
  localparam int NW   = 4;
  localparam int AW   = 16;
  localparam int TW   = 3;
  localparam int WHW  = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           lcl_valid;
  logic [AW-1:0]  lcl_block;
  logic           lcl_read;
  logic [WHW-1:0] lcl_who;
  logic           lcl_ready, lcl_merge, iss_valid, iss_read;
  logic [TW-1:0]  lcl_tag, iss_tag;
  logic [AW-1:0]  iss_block;
  logic           snp_valid;
  logic [TW-1:0]  snp_tag;
  logic [AW-1:0]  snp_block;
  logic           snp_read;
  logic           rsp_valid;
  logic [TW-1:0]  rsp_tag;
  logic           done_valid, tag_err;
  logic [TW-1:0]  done_tag;
  logic [NW-1:0]  done_mask;

  always #2 clk = ~clk;

  split_txn_table #(.NENT(NENT), .NW(NW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .lcl_valid(lcl_valid), .lcl_block(lcl_block), .lcl_read(lcl_read), .lcl_who(lcl_who),
    .lcl_ready(lcl_ready), .lcl_merge(lcl_merge), .lcl_tag(lcl_tag),
    .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_block(iss_block), .iss_read(iss_read),
    .snp_valid(snp_valid), .snp_tag(snp_tag), .snp_block(snp_block), .snp_read(snp_read),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
    .done_valid(done_valid), .done_tag(done_tag), .done_mask(done_mask), .tag_err(tag_err)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // Reference model of the table, written from the requirements
  bit        m_busy [NENT];
  bit        m_rd   [NENT];
  int        m_blk  [NENT];
  bit [3:0]  m_mask [NENT];

  typedef struct {
    bit       is_err;
    int       tag;
    bit [3:0] mask;
    string    req;
  } exp_t;
  exp_t expq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected results as the design reports them
  always @(negedge clk) begin
    if (rst_n && (done_valid || tag_err)) begin
      if (expq.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R3 unexpected result: done=%0d err=%0d expected=none", done_valid, tag_err);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (e.is_err) begin
          chk(tag_err && !done_valid, e.req, "error pulse", {done_valid, tag_err}, 1);
        end else begin
          chk(done_valid && !tag_err, e.req, "done pulse", {done_valid, tag_err}, 2);
          chk(int'(done_tag) == e.tag, e.req, "done_tag", done_tag, e.tag);
          chk(done_mask == e.mask, e.req, "done_mask", done_mask, e.mask);
        end
      end
    end
  end

  // Driver: one bus cycle with any mix of local request, snoop and response
  task automatic cyc(input bit lv, input int lb, input bit lr, input int lw,
                     input bit sv, input int st, input int sb, input bit sr,
                     input bit rv, input int rt, input string req, output int got);
    bit ret [NENT];
    int hi, fr;
    bit mrg, rdy, snp_ok, any_err;
    @(negedge clk);
    lcl_valid = lv; lcl_block = AW'(lb); lcl_read = lr; lcl_who = WHW'(lw);
    snp_valid = sv; snp_tag = TW'(st); snp_block = AW'(sb); snp_read = sr;
    rsp_valid = rv; rsp_tag = TW'(rt);
    #1;
    hi = -1; fr = -1;
    for (int i = 0; i < NENT; i++) ret[i] = rv && (rt == i) && m_busy[i];
    for (int i = 0; i < NENT; i++) if (m_busy[i] && m_blk[i] == lb && !ret[i]) hi = i;
    for (int i = NENT - 1; i >= 0; i--) if (!m_busy[i]) fr = i;
    mrg = (hi >= 0) && lr && m_rd[hi];
    rdy = !sv && (mrg || (hi < 0 && fr >= 0));
    chk(lcl_ready == rdy, req, "lcl_ready", lcl_ready, rdy);
    if (lv) begin
      chk(iss_valid == (rdy && !mrg), req, "iss_valid", iss_valid, rdy && !mrg);
      chk(lcl_merge == (rdy && mrg), req, "lcl_merge", lcl_merge, rdy && mrg);
      if (rdy) chk(int'(lcl_tag) == (mrg ? hi : fr), req, "lcl_tag", lcl_tag, mrg ? hi : fr);
      if (rdy && !mrg) chk(int'(iss_block) == lb && iss_read == lr && iss_tag == lcl_tag,
                           req, "issue fields", iss_block, lb);
    end
    got = int'(lcl_tag);
    snp_ok = sv && !m_busy[st];
    any_err = 1'b0;
    if (rv) begin
      if (m_busy[rt]) expq.push_back('{0, rt, m_mask[rt], req});
      else any_err = 1'b1;
    end
    if (sv && m_busy[st]) any_err = 1'b1;
    if (any_err) expq.push_back('{1, 0, 4'b0, req});
    @(posedge clk);
    for (int i = 0; i < NENT; i++) if (ret[i]) begin m_busy[i] = 0; m_mask[i] = 0; end
    if (lv && rdy) begin
      if (mrg) m_mask[hi] |= 4'(1 << lw);
      else begin m_busy[fr] = 1; m_blk[fr] = lb; m_rd[fr] = lr; m_mask[fr] = 4'(1 << lw); end
    end
    if (snp_ok) begin m_busy[st] = 1; m_blk[st] = sb; m_rd[st] = sr; m_mask[st] = 0; end
    #1;
    lcl_valid = 0; snp_valid = 0; rsp_valid = 0;
  endtask

  task automatic lreq(input int blk, input bit rd, input int who, input string req, output int t);
    cyc(1, blk, rd, who, 0, 0, 0, 0, 0, 0, req, t);
  endtask

  task automatic rsp(input int tag, input string req);
    int t;
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, tag, req, t);
  endtask

  task automatic snoop(input int tag, input int blk, input bit rd, input string req);
    int t;
    cyc(0, 0, 0, 0, 1, tag, blk, rd, 0, 0, req, t);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int t;
    for (int i = 0; i < NENT; i++) begin m_busy[i] = 0; m_rd[i] = 0; m_blk[i] = -1; m_mask[i] = 0; end
    rst_n = 0; lcl_valid = 0; lcl_block = 0; lcl_read = 0; lcl_who = 0;
    snp_valid = 0; snp_tag = 0; snp_block = 0; snp_read = 0; rsp_valid = 0; rsp_tag = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(lcl_ready == 1, "R1", "lcl_ready", lcl_ready, 1);
    chk(iss_valid == 0 && done_valid == 0 && tag_err == 0, "R1", "idle outputs",
        {iss_valid, done_valid, tag_err}, 0);
    chk(lcl_tag == 0, "R1", "first tag", lcl_tag, 0);

    // R2: allocation in lowest-free order
    for (int k = 0; k < 5; k++) begin
      lreq('h100 + k, 0, 0, "R2", t);
      chk(t == k, "R2", "allocated tag", t, k);
    end
    // R6: duplicates stall
    lreq('h101, 0, 1, "R6", t);
    lreq('h101, 1, 1, "R6", t);
    // R3 and R4: retire slot 2, reuse it
    rsp(2, "R3");
    lreq('h200, 0, 0, "R4", t);
    chk(t == 2, "R4", "reused tag", t, 2);
    // R5: snooped request occupies slot 6
    snoop(6, 'h300, 1, "R5");
    lreq('h300, 0, 0, "R5", t);
    lreq('h400, 0, 0, "R5", t);
    chk(t == 5, "R5", "tag", t, 5);
    lreq('h401, 0, 0, "R5", t);
    chk(t == 7, "R5", "tag skips snooped slot", t, 7);
    // R7: reads merge into the outstanding read
    lreq('h300, 1, 2, "R7", t);
    chk(t == 6, "R7", "merged tag", t, 6);
    lreq('h300, 1, 3, "R7", t);
    rsp(6, "R7");
    // R8: full table
    lreq('h500, 1, 0, "R8", t);
    lreq('h600, 0, 0, "R8", t);
    lreq('h500, 1, 1, "R8", t);
    chk(t == 6, "R8", "merge while full", t, 6);
    // R9: response to a free slot
    rsp(3, "R3");
    rsp(3, "R9");
    lreq('h700, 0, 0, "R9", t);
    chk(t == 3, "R9", "table unchanged", t, 3);
    // R10: snoop to a busy slot
    snoop(0, 'h800, 0, "R10");
    lreq('h100, 0, 0, "R10", t);
    rsp(4, "R3");
    lreq('h800, 0, 0, "R10", t);
    chk(t == 4, "R10", "block not taken by rejected snoop", t, 4);
    // R11: snoop and local request together
    rsp(1, "R3");
    cyc(1, 'h900, 0, 0, 1, 1, 'h901, 0, 0, 0, "R11", t);
    lreq('h901, 0, 0, "R11", t);
    // R12: retiring slot invisible to lookup
    rsp(5, "R3");
    cyc(1, 'h500, 1, 2, 0, 0, 0, 0, 1, 6, "R12", t);
    chk(t == 5, "R12", "new slot instead of merge", t, 5);

    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R3", "pending results", expq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule